// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects a parameterized set of interrupt request lines and decides which one the processor should service next. Each line is configured at elaboration time as either an event source or a level source. An event source sets a sticky pending flag when its input pulses. Software clears that flag by writing a one to it, and hardware clears it when the line's vector is taken. A level source has no flag. It requests service for as long as its input stays high.

A per-line enable mask and a single global enable gate all requests. The lowest-numbered eligible line wins. The winner is reported as a vector number equal to the line number plus one, because vector 0 is reserved for reset and ranks above every line. When the processor pulses `take_i`, the block does three things in that clock cycle: it latches the vector number, clears the winner's flag and drops the global enable. Pulsing `reti_i` sets the global enable again. Software may also set the global enable inside a handler, which allows nested interrupts. A plain register port gives access to the enable mask, the flags, the global enable and the raw request lines.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, the enable mask, every flag and the global enable are zero, `irq_pending` is low, and `ack_vec` and `irq_vec` are 0.
- R2: A line is eligible only when its request is active, its bit in the enable mask (register 0, bit i for line i) is one, and the global enable (register 2, bit 0) is one. `irq_pending` is the OR of all eligible lines.
- R3: Among the eligible lines, the lowest line number wins. `irq_vec` shows that line number plus one, and shows 0 when nothing is eligible. Vector 0 is reserved for reset.
- R4: A `take_i` pulse while `irq_pending` is high does three things by the next cycle: `ack_vec` holds the vector that was shown on `irq_vec`, the global enable is zero, and `irq_pending` is low.
- R5: A `reti_i` pulse sets the global enable. A register write to register 2 loads bit 0 into it. In the same cycle, an accepted take beats a write, and a write beats `reti_i`.
- R6: A one on an event line's input sets its flag (register 1, bit i) on the next cycle. An accepted take clears the flag of the winning line only.
- R7: Writing register 1 clears each flag whose data bit is one. Zero bits leave flags unchanged. A new event in the same cycle as any clear leaves the flag set. A hardware clear together with a software clear leaves it clear.
- R8: An event flag raised while its local enable or the global enable is zero stays pending. It is serviced in priority order once both enables are one.
- R9: A level line never shows a flag in register 1. It is eligible whenever its input is high, and a take does not stop its request, so it is taken again after return.
- R10: A `take_i` pulse while `irq_pending` is low changes neither the global enable, nor any flag, nor `ack_vec`.
- R11: Register 3 reads back the raw request of every line: the flag for event lines and the input for level lines, before any enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Request inputs: event pulses or held levels, per line |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 enable, 1 flags, 2 control, 3 raw |
| reg_wdata_i | input | NUM_SRC | Register write data |
| reg_rdata_o | output | NUM_SRC | Register read data (combinational) |
| take_i | input | 1 | Single-cycle interrupt acceptance strobe |
| reti_i | input | 1 | Single-cycle return-from-interrupt strobe |
| irq_pending | output | 1 | Some line is eligible for service |
| irq_vec | output | VEC_W | Vector of the current winner (line + 1), 0 when none |
| ack_vec | output | VEC_W | Vector captured by the last accepted take |

## Verification
The hardest situations to reach are the same-cycle collisions on one flag. One is a new event arriving in the same cycle as a write-one-to-clear. The other is a hardware clear from a take landing in the same cycle as a software clear. Both need the take strobe, the register write and the source pulse driven in one exact cycle. The bench reaches them with a single per-cycle task that drives all strobes together. Priority is swept over every enable mask of the event lines with all flags pending, and the pending set is then drained one take at a time, re-enabling between takes as a nesting handler would.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

   localparam int unsigned REG_ADDR_W = 2;

   typedef enum logic [REG_ADDR_W-1:0] {
      RA_ENABLE = 2'd0,
      RA_FLAGS  = 2'd1,
      RA_CTRL   = 2'd2,
      RA_RAW    = 2'd3
   } reg_addr_e;

   localparam int unsigned MIN_SRC = 8;
   localparam int unsigned MAX_SRC = 32;

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int unsigned NUM_SRC    = 8,
   parameter logic [31:0] LEVEL_MASK = 32'h0000_00C0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [NUM_SRC-1:0] hw_clr_i,
   input  logic [NUM_SRC-1:0] sw_clr_i,
   output logic [NUM_SRC-1:0] flag_o,
   output logic [NUM_SRC-1:0] req_o
);

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      if (LEVEL_MASK[i]) begin : g_level
         logic unused_clr;
         assign unused_clr = hw_clr_i[i] | sw_clr_i[i];
         assign flag_o[i]  = 1'b0;
         assign req_o[i]   = src_i[i];
      end else begin : g_event
         logic flag_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               flag_q <= 1'b0;
            else
               flag_q <= src_i[i] | (flag_q & ~(hw_clr_i[i] | sw_clr_i[i]));
         end
         assign flag_o[i] = flag_q;
         assign req_o[i]  = flag_q;

         // R7: a fresh event wins over any clear
         a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
            src_i[i] |=> flag_o[i]);
         // R7: a write-one-to-clear without an event empties the flag
         a_r7_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_clr_i[i] && !src_i[i]) |=> !flag_o[i]);
         // R8: with no clear the flag is remembered
         a_r8_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_o[i] && !hw_clr_i[i] && !sw_clr_i[i]) |=> flag_o[i]);
      end
   end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int unsigned NUM_SRC = 8,
   parameter int unsigned VEC_W   = $clog2(NUM_SRC + 1)
) (
   input  logic [NUM_SRC-1:0] elig_i,
   output logic               any_o,
   output logic [NUM_SRC-1:0] grant_o,
   output logic [VEC_W-1:0]   vec_o
);

   assign any_o   = |elig_i;
   assign grant_o = elig_i & (~elig_i + NUM_SRC'(1));

   always_comb begin
      vec_o = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (elig_i[i]) vec_o = VEC_W'(i + 1);
      end
   end

endmodule

// File: rtl/irq_regs.sv
module irq_regs
   import irq_ctrl_pkg::*;
#(
   parameter int unsigned NUM_SRC = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we_i,
   input  logic [REG_ADDR_W-1:0] addr_i,
   input  logic [NUM_SRC-1:0]    wdata_i,
   input  logic                  take_acc_i,
   input  logic                  reti_i,
   input  logic [NUM_SRC-1:0]    flag_i,
   input  logic [NUM_SRC-1:0]    raw_i,
   output logic [NUM_SRC-1:0]    en_o,
   output logic                  gie_o,
   output logic [NUM_SRC-1:0]    sw_clr_o,
   output logic [NUM_SRC-1:0]    rdata_o
);

   logic [NUM_SRC-1:0] en_q;
   logic               gie_q;
   logic               wr_en, wr_flags, wr_ctrl;

   assign wr_en    = we_i && (addr_i == RA_ENABLE);
   assign wr_flags = we_i && (addr_i == RA_FLAGS);
   assign wr_ctrl  = we_i && (addr_i == RA_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q <= '0;
      else if (wr_en) en_q <= wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          gie_q <= 1'b0;
      else if (take_acc_i) gie_q <= 1'b0;
      else if (wr_ctrl)    gie_q <= wdata_i[0];
      else if (reti_i)     gie_q <= 1'b1;
   end

   assign sw_clr_o = wr_flags ? wdata_i : '0;
   assign en_o     = en_q;
   assign gie_o    = gie_q;

   always_comb begin
      unique case (addr_i)
         RA_ENABLE: rdata_o = en_q;
         RA_FLAGS:  rdata_o = flag_i;
         RA_CTRL:   rdata_o = NUM_SRC'(gie_q);
         default:   rdata_o = raw_i;
      endcase
   end

   // R4: taking an interrupt masks everything
   a_r4_take_masks: assert property (@(posedge clk) disable iff (!rst_n)
      take_acc_i |=> !gie_o);
   // R5: return re-enables unless a write or take overrides it
   a_r5_reti_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (reti_i && !take_acc_i && !wr_ctrl) |=> gie_o);
   // R5: software write loads the global enable
   a_r5_sw_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !take_acc_i) |=> (gie_o == $past(wdata_i[0])));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import irq_ctrl_pkg::*;
#(
   parameter int unsigned NUM_SRC    = 8,
   parameter logic [31:0] LEVEL_MASK = 32'h0000_00C0,
   parameter int unsigned VEC_W      = $clog2(NUM_SRC + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_SRC-1:0]    src_i,
   input  logic                  reg_we_i,
   input  logic [REG_ADDR_W-1:0] reg_addr_i,
   input  logic [NUM_SRC-1:0]    reg_wdata_i,
   output logic [NUM_SRC-1:0]    reg_rdata_o,
   input  logic                  take_i,
   input  logic                  reti_i,
   output logic                  irq_pending,
   output logic [VEC_W-1:0]      irq_vec,
   output logic [VEC_W-1:0]      ack_vec
);

   if (NUM_SRC < MIN_SRC || NUM_SRC > MAX_SRC) begin : g_bad_count
      $error("prio_irq_ctrl: NUM_SRC must lie between 8 and 32");
   end
   if (VEC_W < $clog2(NUM_SRC + 1)) begin : g_bad_vec
      $error("prio_irq_ctrl: VEC_W too narrow for NUM_SRC + 1 vectors");
   end

   logic [NUM_SRC-1:0] flag, req, en, sw_clr, hw_clr, elig, grant;
   logic               gie, any, take_acc;
   logic [VEC_W-1:0]   win_vec;
   logic [VEC_W-1:0]   ack_q;

   irq_flag_bank #(.NUM_SRC(NUM_SRC), .LEVEL_MASK(LEVEL_MASK)) u_flags (
      .clk(clk), .rst_n(rst_n), .src_i(src_i),
      .hw_clr_i(hw_clr), .sw_clr_i(sw_clr),
      .flag_o(flag), .req_o(req)
   );

   irq_regs #(.NUM_SRC(NUM_SRC)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
      .take_acc_i(take_acc), .reti_i(reti_i),
      .flag_i(flag), .raw_i(req),
      .en_o(en), .gie_o(gie), .sw_clr_o(sw_clr), .rdata_o(reg_rdata_o)
   );

   assign elig = req & en & {NUM_SRC{gie}};

   irq_prio_pick #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_pick (
      .elig_i(elig), .any_o(any), .grant_o(grant), .vec_o(win_vec)
   );

   assign take_acc = take_i & any;
   assign hw_clr   = take_acc ? grant : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ack_q <= '0;
      else if (take_acc) ack_q <= win_vec;
   end

   assign irq_pending = any;
   assign irq_vec     = win_vec;
   assign ack_vec     = ack_q;

   // R3: the granted line is eligible and no lower line is
   a_r3_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pending |-> ($onehot(grant) && ((grant & elig) == grant)
                       && ((elig & (grant - NUM_SRC'(1))) == '0) && (irq_vec != '0)));
   // R4: the acknowledged vector is the one shown at the take
   a_r4_ack_capture: assert property (@(posedge clk) disable iff (!rst_n)
      take_acc |=> (ack_vec == $past(irq_vec)));
   // R10: a take with nothing pending leaves the acknowledge alone
   a_r10_idle_take: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && !irq_pending) |=> $stable(ack_vec));
   // R2: no pending request without the global enable
   a_r2_gie_gates: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata_o == '0 && reg_addr_i == RA_CTRL) |-> !irq_pending);

endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;

   localparam int N = 8;
   localparam int VW = 4;
   localparam logic [N-1:0] LVL = 8'hC0;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  src_i = '0;
   logic          reg_we_i = 1'b0;
   logic [1:0]    reg_addr_i = 2'd0;
   logic [N-1:0]  reg_wdata_i = '0;
   logic [N-1:0]  reg_rdata_o;
   logic          take_i = 1'b0, reti_i = 1'b0;
   logic          irq_pending;
   logic [VW-1:0] irq_vec, ack_vec;

   logic [N-1:0]  lvl_hold = '0;
   int total = 0, bad = 0;

   always #5 clk = ~clk;

   prio_irq_ctrl #(.NUM_SRC(N), .LEVEL_MASK(32'h0000_00C0)) dut_i (
      .clk(clk), .rst_n(rst_n), .src_i(src_i),
      .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
      .reg_rdata_o(reg_rdata_o), .take_i(take_i), .reti_i(reti_i),
      .irq_pending(irq_pending), .irq_vec(irq_vec), .ack_vec(ack_vec)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one clock with every strobe chosen together
   task automatic cyc(input logic we, input logic [1:0] a, input logic [N-1:0] d,
                      input logic [N-1:0] pulse, input logic tk, input logic rt);
      reg_we_i = we; reg_addr_i = a; reg_wdata_i = d;
      src_i = lvl_hold | (pulse & ~LVL); take_i = tk; reti_i = rt;
      @(negedge clk);
      reg_we_i = 1'b0; src_i = lvl_hold; take_i = 1'b0; reti_i = 1'b0;
      #1;
   endtask

   task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
      cyc(1'b1, a, d, '0, 1'b0, 1'b0);
   endtask

   task automatic rd(input logic [1:0] a, output logic [N-1:0] v);
      reg_addr_i = a; #1; v = reg_rdata_o;
   endtask

   function automatic int lowest_vec(input logic [N-1:0] m);
      for (int i = N - 1; i >= 0; i--) if (m[i]) lowest_vec = i + 1;
      if (m == '0) lowest_vec = 0;
   endfunction

   initial begin : watchdog
      #1_000_000;
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : stim
      logic [N-1:0] v;
      repeat (3) @(negedge clk);
      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v); chk("R1 reg", int'(v), 0);
      end
      chk("R1 pending", int'(irq_pending), 0);
      chk("R1 ack", int'(ack_vec), 0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R1 vec", int'(irq_vec), 0);

      // R6 event sets flag; R7 zero write no effect, one write clears
      cyc(1'b0, 2'd0, '0, 8'h04, 1'b0, 1'b0);
      rd(2'd1, v); chk("R6 flag set", int'(v), 'h04);
      rd(2'd3, v); chk("R11 raw", int'(v), 'h04);
      wr(2'd1, 8'h00);
      rd(2'd1, v); chk("R7 zero write", int'(v), 'h04);
      wr(2'd1, 8'h04);
      rd(2'd1, v); chk("R7 w1c", int'(v), 0);

      // R2 / R8 masked flag stays pending
      cyc(1'b0, 2'd0, '0, 8'h08, 1'b0, 1'b0);
      chk("R2 no enables", int'(irq_pending), 0);
      wr(2'd0, 8'h08);
      chk("R2 gie off", int'(irq_pending), 0);
      wr(2'd2, 8'h01);
      chk("R8 later serviced", int'(irq_pending), 1);
      chk("R8 vec", int'(irq_vec), 4);
      wr(2'd0, 8'h00);
      chk("R2 local off", int'(irq_pending), 0);
      wr(2'd1, 8'hFF);

      // R3 sweep every enable mask over all event lines
      cyc(1'b0, 2'd0, '0, 8'h3F, 1'b0, 1'b0);
      for (int m = 0; m < 64; m++) begin
         wr(2'd0, 8'(m));
         chk("R3 pending", int'(irq_pending), (m != 0) ? 1 : 0);
         chk("R3 vec", int'(irq_vec), lowest_vec(8'(m)));
      end

      // R4 / R6 drain in order, re-enabling like a nesting handler
      wr(2'd0, 8'h3F);
      for (int k = 0; k < 6; k++) begin
         chk("R3 drain vec", int'(irq_vec), k + 1);
         cyc(1'b0, 2'd0, '0, '0, 1'b1, 1'b0);
         chk("R4 ack", int'(ack_vec), k + 1);
         chk("R4 pending low", int'(irq_pending), 0);
         rd(2'd2, v); chk("R4 gie cleared", int'(v), 0);
         rd(2'd1, v); chk("R6 hw clear", int'(v), int'(8'h3F & ~8'((2 << k) - 1)));
         wr(2'd2, 8'h01);
      end

      // R10 take with nothing pending
      cyc(1'b0, 2'd0, '0, '0, 1'b1, 1'b0);
      chk("R10 ack", int'(ack_vec), 6);
      rd(2'd2, v); chk("R10 gie", int'(v), 1);

      // R5 return, and strobe precedence
      cyc(1'b0, 2'd0, '0, 8'h01, 1'b0, 1'b0);
      cyc(1'b0, 2'd0, '0, '0, 1'b1, 1'b0);
      rd(2'd2, v); chk("R5 taken", int'(v), 0);
      cyc(1'b0, 2'd0, '0, '0, 1'b0, 1'b1);
      rd(2'd2, v); chk("R5 reti sets", int'(v), 1);
      wr(2'd2, 8'h00);
      cyc(1'b1, 2'd2, 8'h00, '0, 1'b0, 1'b1);
      rd(2'd2, v); chk("R5 write beats reti", int'(v), 0);
      wr(2'd2, 8'h01);
      cyc(1'b0, 2'd0, '0, 8'h02, 1'b0, 1'b0);
      cyc(1'b1, 2'd2, 8'h01, '0, 1'b1, 1'b0);
      rd(2'd2, v); chk("R5 take beats write", int'(v), 0);

      // R9 level lines
      wr(2'd0, 8'hC0);
      wr(2'd2, 8'h01);
      lvl_hold = 8'h80; src_i = lvl_hold; #1;
      chk("R9 pending", int'(irq_pending), 1);
      chk("R9 vec", int'(irq_vec), 8);
      cyc(1'b0, 2'd0, '0, '0, 1'b1, 1'b0);
      chk("R9 ack", int'(ack_vec), 8);
      rd(2'd1, v); chk("R9 no flag", int'(v), 0);
      rd(2'd3, v); chk("R11 level raw", int'(v), 'h80);
      cyc(1'b0, 2'd0, '0, '0, 1'b0, 1'b1);
      chk("R9 retaken", int'(irq_vec), 8);
      lvl_hold = 8'hC0; src_i = lvl_hold; #1;
      chk("R9 prio", int'(irq_vec), 7);
      lvl_hold = 8'h00; src_i = lvl_hold; #1;
      chk("R9 released", int'(irq_pending), 0);

      // R7 event coincident with clear; hw plus sw clear
      wr(2'd1, 8'hFF);
      cyc(1'b1, 2'd1, 8'h02, 8'h02, 1'b0, 1'b0);
      rd(2'd1, v); chk("R7 event wins", int'(v), 'h02);
      wr(2'd0, 8'h02);
      chk("R7 pending", int'(irq_vec), 2);
      cyc(1'b1, 2'd1, 8'h02, '0, 1'b1, 1'b0);
      rd(2'd1, v); chk("R7 double clear", int'(v), 0);
      chk("R7 ack", int'(ack_vec), 2);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule